// File: doc/BRIEF.md
# Context-Tagged Virtual Cache Tag Controller

This block holds the tag store and control path of a direct-mapped cache that is both indexed and tagged by virtual address. Each tag records which address space (context) owns the line, and it keeps copies of the page's writable and privileged permission bits. A lookup therefore checks three things: the address, context ownership, and access rights. The result is hit, miss or protection fault, registered one cycle after the request. Stores are always forwarded to memory, because the cache is write-through.

Lines are installed by a fill strobe from the refill logic. The fill carries the context and the page permission bits for the new line. Software controls the block in three ways. A global enable turns caching off. A single line can be invalidated by address. Every line of one context can be invalidated by a walk that visits one index per cycle. A diagnostic port reads and writes raw tag words in a fixed 32-bit layout. After reset, the whole tag store is cleared by the same walk, and requests are held off until the walk ends.

Top module: `vtag_ctl`

## Requirements
- R1: After reset `busy` stays high for exactly 4096 cycles while every tag is cleared. Lookups, fills and diagnostic accesses made while `busy` is high are ignored, and `resp_valid` stays low for them. After the clear, every lookup misses.
- R2: Address bits 15:4 select one of 4096 lines and bits 29:16 are the 14-bit tag. Bits 31:30 and 3:0 have no effect on the lookup result.
- R3: A lookup matches only when the entry is valid, its stored tag equals address bits 29:16, and its stored context equals `req_ctx`. A context mismatch gives a miss.
- R4: A matching lookup on a line whose privileged bit is set, made with `req_super` low, gives `resp_fault` instead of `resp_hit`.
- R5: A matching store on a line whose writable bit is clear gives `resp_fault`.
- R6: A fill writes the indexed line as valid, with `fill_ctx`, `fill_wr_ok` and `fill_priv`, and replaces whatever was there. A lookup never allocates, so a store miss or load miss followed by another lookup still misses.
- R7: `cache_en` resets to 0 and is loaded from `ctl_en` when `ctl_we` is high. While it is 0, every lookup misses and fills are dropped, and the stored tags are kept.
- R8: `flush_line` clears the valid bit of the line indexed by `flush_addr` bits 15:4.
- R9: `flush_ctx_go` starts a walk that lasts 4096 cycles with `busy` high. The walk invalidates every valid line whose context equals `flush_ctx_id` and leaves the lines of other contexts intact.
- R10: The diagnostic tag word has context in bits 24:22, writable in 21, privileged in 20, valid in 19 and tag in 15:2. All other bits read as 0. `diag_we` writes the entry at `diag_idx`. `diag_re` returns that entry on `diag_rdata` one cycle later.
- R11: If a diagnostic write and a fill target the same index in the same cycle, the diagnostic write wins.
- R12: Every accepted store raises `resp_mem_wr` with its response, whether it hits, misses, faults or the cache is disabled. Loads never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the enable bit |
| ctl_en | input | 1 | New enable value |
| cache_en | output | 1 | Current global cache enable |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Virtual address of the lookup |
| req_ctx | input | 3 | Current context |
| req_write | input | 1 | 1 = store, 0 = load |
| req_super | input | 1 | Supervisor mode |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup hit |
| resp_miss | output | 1 | Lookup miss |
| resp_fault | output | 1 | Protection fault |
| resp_mem_wr | output | 1 | Store forwarded to memory |
| fill_valid | input | 1 | Fill strobe |
| fill_addr | input | 32 | Virtual address of the filled line |
| fill_ctx | input | 3 | Owning context of the fill |
| fill_wr_ok | input | 1 | Page writable bit |
| fill_priv | input | 1 | Page privileged bit |
| flush_line | input | 1 | Invalidate one line |
| flush_addr | input | 32 | Address of the line to invalidate |
| flush_ctx_go | input | 1 | Start a context flush walk |
| flush_ctx_id | input | 3 | Context to flush |
| busy | output | 1 | Clear or flush walk in progress |
| diag_we | input | 1 | Diagnostic tag write |
| diag_re | input | 1 | Diagnostic tag read |
| diag_idx | input | 12 | Diagnostic line index |
| diag_wdata | input | 32 | Diagnostic tag word to write |
| diag_rdata | output | 32 | Diagnostic tag word read |

## Verification
The bench targets the cases that are easy to get wrong:
- Address bits outside the tag and index fields must be ignored. A design that compared them would miss on hits.
- A context mismatch must miss. A design that skipped the check would hit on another context's line.
- User-mode access to a privileged line must fault, and so must a store to a read-only line. A design without these checks would report hits.
- A disabled cache must neither hit nor install lines.
- A context walk must leave other contexts' lines intact and hold `busy` for exactly the line count. A wrong walk would either wipe too much or leave stale lines behind.
- A diagnostic write that collides with a fill must beat it. Reversed priority would leave the fill's tag in place.
- The raw tag-word layout is checked with all ones written: misplaced or unmasked fields read back wrong.

// File: rtl/vtag_ctl.sv
module vtag_ctl #(
  parameter int OFF_W = 4,
  parameter int IDX_W = 12,
  parameter int TAG_W = 14,
  parameter int CTX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_en,
  output logic             cache_en,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             req_write,
  input  logic             req_super,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_fault,
  output logic             resp_mem_wr,
  input  logic             fill_valid,
  input  logic [31:0]      fill_addr,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic             fill_wr_ok,
  input  logic             fill_priv,
  input  logic             flush_line,
  input  logic [31:0]      flush_addr,
  input  logic             flush_ctx_go,
  input  logic [CTX_W-1:0] flush_ctx_id,
  output logic             busy,
  input  logic             diag_we,
  input  logic             diag_re,
  input  logic [IDX_W-1:0] diag_idx,
  input  logic [31:0]      diag_wdata,
  output logic [31:0]      diag_rdata
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_LO = OFF_W + IDX_W;
  localparam int ENT_W  = TAG_W + CTX_W + 3;
  localparam int E_V    = ENT_W - 1;
  localparam int E_CTX  = TAG_W + 2;
  localparam int E_W    = TAG_W + 1;
  localparam int E_P    = TAG_W;
  localparam int D_CTX  = 22;
  localparam int D_W    = 21;
  localparam int D_P    = 20;
  localparam int D_V    = 19;
  localparam int D_TAG  = 2;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_FLUSH} walk_t;

  logic [ENT_W-1:0] tags [DEPTH];
  walk_t            st;
  logic [IDX_W-1:0] walk_idx;
  logic [CTX_W-1:0] walk_ctx;

  function automatic logic [31:0] to_word(input logic [ENT_W-1:0] e);
    logic [31:0] w;
    w = '0;
    w[D_CTX +: CTX_W] = e[E_CTX +: CTX_W];
    w[D_W]            = e[E_W];
    w[D_P]            = e[E_P];
    w[D_V]            = e[E_V];
    w[D_TAG +: TAG_W] = e[TAG_W-1:0];
    return w;
  endfunction

  function automatic logic [ENT_W-1:0] from_word(input logic [31:0] w);
    return {w[D_V], w[D_CTX +: CTX_W], w[D_W], w[D_P], w[D_TAG +: TAG_W]};
  endfunction

  assign busy = (st != S_IDLE);

  wire [IDX_W-1:0] req_idx  = req_addr[OFF_W +: IDX_W];
  wire [ENT_W-1:0] req_ent  = tags[req_idx];
  wire             accept   = req_valid && !busy;
  wire             match    = cache_en && req_ent[E_V] &&
                              req_ent[TAG_W-1:0] == req_addr[TAG_LO +: TAG_W] &&
                              req_ent[E_CTX +: CTX_W] == req_ctx;
  wire             deny     = (req_ent[E_P] && !req_super) || (req_write && !req_ent[E_W]);

  wire [IDX_W-1:0] fill_idx  = fill_addr[OFF_W +: IDX_W];
  wire [IDX_W-1:0] flush_idx = flush_addr[OFF_W +: IDX_W];
  wire [ENT_W-1:0] walk_ent  = tags[walk_idx];

  logic unused_bits;
  assign unused_bits = ^{req_addr[31:TAG_LO+TAG_W], req_addr[OFF_W-1:0],
                         fill_addr[31:OFF_W+IDX_W], fill_addr[OFF_W-1:0],
                         flush_addr[31:OFF_W+IDX_W], flush_addr[OFF_W-1:0],
                         diag_wdata[31:D_CTX+CTX_W], diag_wdata[D_V-1:D_TAG+TAG_W],
                         diag_wdata[D_TAG-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_INIT;
      walk_idx <= '0;
      walk_ctx <= '0;
    end else if (st == S_IDLE) begin
      if (flush_ctx_go) begin
        st       <= S_FLUSH;
        walk_ctx <= flush_ctx_id;
        walk_idx <= '0;
      end
    end else begin
      walk_idx <= walk_idx + 1'b1;
      if (&walk_idx) st <= S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_INIT) begin
      tags[walk_idx] <= '0;
    end else if (st == S_FLUSH) begin
      if (walk_ent[E_V] && walk_ent[E_CTX +: CTX_W] == walk_ctx)
        tags[walk_idx][E_V] <= 1'b0;
    end else begin
      if (fill_valid && cache_en)
        tags[fill_idx] <= {1'b1, fill_ctx, fill_wr_ok, fill_priv, fill_addr[TAG_LO +: TAG_W]};
      if (flush_line)
        tags[flush_idx][E_V] <= 1'b0;
      if (diag_we)
        tags[diag_idx] <= from_word(diag_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_en    <= 1'b0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_miss   <= 1'b0;
      resp_fault  <= 1'b0;
      resp_mem_wr <= 1'b0;
      diag_rdata  <= '0;
    end else begin
      if (ctl_we) cache_en <= ctl_en;
      resp_valid  <= accept;
      resp_hit    <= accept && match && !deny;
      resp_fault  <= accept && match && deny;
      resp_miss   <= accept && !match;
      resp_mem_wr <= accept && req_write;
      if (diag_re && !busy) diag_rdata <= to_word(tags[diag_idx]);
    end
  end
endmodule

// File: rtl/vtag_ctl_chk.sv
module vtag_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic cache_en,
  input logic req_valid,
  input logic req_write,
  input logic req_super,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_miss,
  input logic resp_fault,
  input logic resp_mem_wr,
  input logic flush_ctx_go,
  input logic busy
);
  a_r1_no_resp_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid) && !$past(busy)));

  a_r1_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_hit || resp_miss || resp_fault || resp_mem_wr));

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_hit, resp_miss, resp_fault}) == 1);

  a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> ($past(req_write) || !$past(req_super)));

  a_r7_off_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !$past(cache_en)) |-> resp_miss);

  a_r12_store_through: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_write)) |-> resp_mem_wr);

  a_r9_walk_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && flush_ctx_go) |=> busy);
endmodule

bind vtag_ctl vtag_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .req_valid(req_valid),
  .req_write(req_write), .req_super(req_super), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
  .resp_mem_wr(resp_mem_wr), .flush_ctx_go(flush_ctx_go), .busy(busy)
);

// File: tb/vtag_ctl_test.sv
module vtag_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4096;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_en = 0, cache_en;
  logic req_valid = 0, req_write = 0, req_super = 0;
  logic [31:0] req_addr = '0;
  logic [2:0] req_ctx = '0;
  logic resp_valid, resp_hit, resp_miss, resp_fault, resp_mem_wr;
  logic fill_valid = 0, fill_wr_ok = 0, fill_priv = 0;
  logic [31:0] fill_addr = '0;
  logic [2:0] fill_ctx = '0;
  logic flush_line = 0, flush_ctx_go = 0;
  logic [31:0] flush_addr = '0;
  logic [2:0] flush_ctx_id = '0;
  logic busy;
  logic diag_we = 0, diag_re = 0;
  logic [11:0] diag_idx = '0;
  logic [31:0] diag_wdata = '0, diag_rdata;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtag_ctl uut (.*);

  localparam logic [1:0] NONE = 2'd0, HIT = 2'd1, MISS = 2'd2, FAULT = 2'd3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [2:0] c, input logic w, input logic p,
                                       input logic v, input logic [13:0] t);
    return (32'(c) << 22) | (32'(w) << 21) | (32'(p) << 20) | (32'(v) << 19) | (32'(t) << 2);
  endfunction

  task automatic lookup(input logic [31:0] a, input logic [2:0] c, input logic wr,
                        input logic sup, output logic [1:0] res, output logic mw);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_ctx = c; req_write = wr; req_super = sup;
    @(negedge clk);
    res = !resp_valid ? NONE : resp_hit ? HIT : resp_miss ? MISS : resp_fault ? FAULT : NONE;
    mw = resp_mem_wr;
    req_valid = 0;
  endtask

  task automatic expect_look(input string req, input logic [31:0] a, input logic [2:0] c,
                             input logic wr, input logic sup, input logic [1:0] exp);
    logic [1:0] r; logic mw;
    lookup(a, c, wr, sup, r, mw);
    chk(req, 32'(r), 32'(exp));
  endtask

  task automatic fill(input logic [31:0] a, input logic [2:0] c, input logic w, input logic p);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_ctx = c; fill_wr_ok = w; fill_priv = p;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic set_en(input logic e);
    @(negedge clk);
    ctl_we = 1; ctl_en = e;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic diag_write(input logic [11:0] i, input logic [31:0] d);
    @(negedge clk);
    diag_we = 1; diag_idx = i; diag_wdata = d;
    @(negedge clk);
    diag_we = 0;
  endtask

  task automatic diag_read(input logic [11:0] i, output logic [31:0] d);
    @(negedge clk);
    diag_re = 1; diag_idx = i;
    @(negedge clk);
    d = diag_rdata;
    diag_re = 0;
  endtask

  task automatic t_reset;
    int n = 0;
    logic seen = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 enable off at reset", 32'(cache_en), 32'd0);
    rst_n = 1;
    req_valid = 1; req_addr = 32'h0012_3450;
    while (busy) begin
      n++;
      if (resp_valid) seen = 1;
      @(negedge clk);
    end
    req_valid = 0;
    chk("R1 busy cycles after reset", 32'(n), 32'(LINES));
    chk("R1 no response while clearing", 32'(seen), 32'd0);
    set_en(1);
    expect_look("R1 miss after clear", 32'h0012_3450, 3'd2, 0, 1, MISS);
    expect_look("R1 miss after clear far line", 32'h3FFF_FFF0, 3'd0, 0, 1, MISS);
  endtask

  task automatic t_addr;
    fill(32'h0012_3450, 3'd2, 1, 0);
    expect_look("R6 fill then hit", 32'h0012_3450, 3'd2, 0, 0, HIT);
    expect_look("R2 ignored bits 31:30 and 3:0", 32'hC012_345F, 3'd2, 0, 0, HIT);
    expect_look("R2 tag differs", 32'h0013_3450, 3'd2, 0, 0, MISS);
    expect_look("R2 index differs", 32'h0012_3460, 3'd2, 0, 0, MISS);
  endtask

  task automatic t_ctx;
    expect_look("R3 other context misses", 32'h0012_3450, 3'd3, 0, 0, MISS);
  endtask

  task automatic t_priv;
    fill(32'h0100_1000, 3'd2, 1, 1);
    expect_look("R4 user on privileged line", 32'h0100_1000, 3'd2, 0, 0, FAULT);
    expect_look("R4 supervisor on privileged line", 32'h0100_1000, 3'd2, 0, 1, HIT);
  endtask

  task automatic t_store;
    logic [1:0] r; logic mw;
    fill(32'h0200_2000, 3'd2, 0, 0);
    lookup(32'h0200_2000, 3'd2, 1, 1, r, mw);
    chk("R5 store to read-only line", 32'(r), 32'(FAULT));
    chk("R12 faulting store goes to memory", 32'(mw), 32'd1);
    lookup(32'h0012_3450, 3'd2, 1, 0, r, mw);
    chk("R5 store to writable line", 32'(r), 32'(HIT));
    chk("R12 store hit goes to memory", 32'(mw), 32'd1);
    lookup(32'h0300_3000, 3'd2, 1, 0, r, mw);
    chk("R12 store miss goes to memory", 32'(mw), 32'd1);
    lookup(32'h0012_3450, 3'd2, 0, 0, r, mw);
    chk("R12 load no memory write", 32'(mw), 32'd0);
  endtask

  task automatic t_no_alloc;
    expect_look("R6 store miss no allocate", 32'h0300_3000, 3'd2, 0, 0, MISS);
    expect_look("R6 load miss first", 32'h0400_4000, 3'd2, 0, 0, MISS);
    expect_look("R6 load miss again", 32'h0400_4000, 3'd2, 0, 0, MISS);
    fill(32'h0300_3000, 3'd4, 1, 0);
    fill(32'h0500_3000, 3'd4, 1, 0);
    expect_look("R6 refill replaces line", 32'h0500_3000, 3'd4, 0, 0, HIT);
    expect_look("R6 old tag gone", 32'h0300_3000, 3'd4, 0, 0, MISS);
  endtask

  task automatic t_disable;
    logic [1:0] r; logic mw;
    set_en(0);
    chk("R7 enable cleared", 32'(cache_en), 32'd0);
    expect_look("R7 disabled lookup misses", 32'h0012_3450, 3'd2, 0, 0, MISS);
    lookup(32'h0012_3450, 3'd2, 1, 0, r, mw);
    chk("R12 store through when disabled", 32'(mw), 32'd1);
    fill(32'h0600_6000, 3'd2, 1, 0);
    set_en(1);
    expect_look("R7 disabled fill dropped", 32'h0600_6000, 3'd2, 0, 0, MISS);
    expect_look("R7 tags kept across disable", 32'h0012_3450, 3'd2, 0, 0, HIT);
  endtask

  task automatic t_flush_line;
    @(negedge clk);
    flush_line = 1; flush_addr = 32'hC012_345C;
    @(negedge clk);
    flush_line = 0;
    expect_look("R8 flushed line misses", 32'h0012_3450, 3'd2, 0, 0, MISS);
    expect_look("R8 other line kept", 32'h0100_1000, 3'd2, 0, 1, HIT);
  endtask

  task automatic t_flush_ctx;
    int n = 0;
    fill(32'h0700_7000, 3'd5, 1, 0);
    fill(32'h0800_8000, 3'd5, 1, 0);
    fill(32'h0900_9000, 3'd1, 1, 0);
    @(negedge clk);
    flush_ctx_go = 1; flush_ctx_id = 3'd5;
    @(negedge clk);
    flush_ctx_go = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R9 walk length", 32'(n), 32'(LINES));
    expect_look("R9 context line A flushed", 32'h0700_7000, 3'd5, 0, 0, MISS);
    expect_look("R9 context line B flushed", 32'h0800_8000, 3'd5, 0, 0, MISS);
    expect_look("R9 other context kept", 32'h0900_9000, 3'd1, 0, 0, HIT);
  endtask

  task automatic t_diag;
    logic [31:0] d;
    diag_write(12'h345, 32'hFFFF_FFFF);
    diag_read(12'h345, d);
    chk("R10 unused bits read zero", d, 32'h01F8_FFFC);
    diag_write(12'h567, word(3'd2, 1, 0, 1, 14'h2ABC));
    expect_look("R10 written tag hits", 32'h2ABC_5670, 3'd2, 0, 0, HIT);
    diag_read(12'h900, d);
    chk("R10 filled entry layout", d, word(3'd1, 1, 0, 1, 14'h0900));
  endtask

  task automatic t_prio;
    @(negedge clk);
    fill_valid = 1; fill_addr = 32'h0111_7770; fill_ctx = 3'd2; fill_wr_ok = 1; fill_priv = 0;
    diag_we = 1; diag_idx = 12'h777; diag_wdata = word(3'd2, 1, 0, 1, 14'h0222);
    @(negedge clk);
    fill_valid = 0; diag_we = 0;
    expect_look("R11 fill lost to diag write", 32'h0111_7770, 3'd2, 0, 0, MISS);
    expect_look("R11 diag tag present", 32'h0222_7770, 3'd2, 0, 0, HIT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_addr();
    t_ctx();
    t_priv();
    t_store();
    t_no_alloc();
    t_disable();
    t_flush_line();
    t_flush_ctx();
    t_diag();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule